// File: doc/BRIEF.md
# Response Frame Integrity Checker

This block watches the bytes received during one serial transaction whose total length is known in advance. It does not store the frame. It tracks where each incoming byte sits in the frame and runs a CRC-32 over an optional payload window. It collects the 32-bit checksum the far end sent after that window, and it captures the status byte that opens the four-byte trailer at the end of the frame. When the last byte arrives, it reports an error vector, a work-accepted flag and a one-cycle completion strobe.

A transaction begins with a `start` pulse. This pulse also latches the frame length and the payload length. Received bytes then arrive as `rx_byte` qualified by `rx_valid`, and they may have idle cycles between them. The payload window always begins at byte 4. A payload length of zero turns the checksum comparison off. The three bytes after the status byte are an address that the block does not inspect.

The block assumes the frame is at least 4 bytes long. When a payload is checked, it also assumes the frame is long enough to hold the 4-byte header, the payload, the 4-byte checksum and the 4-byte trailer.

Top module: `rsp_integrity_chk`

## Requirements
- R1: A `start` pulse clears `err_vec` and `work_ok` in the following cycle, latches `xfer_len` and `chk_len`, and makes the next accepted byte byte 0. A byte presented together with `start` is not counted.
- R2: `done` is high for exactly one cycle: the cycle after byte number `xfer_len`-1 is accepted. Bytes that arrive after that, and before the next `start`, are ignored.
- R3: The status byte is byte `xfer_len`-4, and the three bytes after it have no effect. If the status byte, with bits 5 and 2 forced to zero, differs from 8'h81, then `err_vec` bit 2 is set.
- R4: If status bit 5 is set, then `err_vec` bit 0 is set.
- R5: The block computes a CRC-32 over bytes 4 through 3+`chk_len`. The CRC uses the reflected polynomial 32'hEDB88320, an all-ones start value and an inverted result. The block compares it with bytes 4+`chk_len` to 7+`chk_len` read as a 32-bit value, most significant byte first. A mismatch sets `err_vec` bit 1.
- R6: When `chk_len` is zero, `err_vec` bit 1 stays clear, whatever bytes are received.
- R7: `work_ok` is 1 only when all three `err_vec` bits are zero and status bit 2 is set.
- R8: `err_vec` and `work_ok` keep their values from `done` until the next `start`.
- R9: A cycle with `rx_valid` low does not advance the byte position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a transaction and latches the lengths |
| xfer_len | input | LEN_W | Total frame length in bytes |
| chk_len | input | LEN_W | Payload length in bytes covered by the CRC; 0 disables the check |
| rx_valid | input | 1 | `rx_byte` holds a received byte |
| rx_byte | input | 8 | Received byte |
| err_vec | output | 3 | Bit 0 request-CRC flag, bit 1 payload CRC mismatch, bit 2 bad status |
| work_ok | output | 1 | Work accepted and no error |
| done | output | 1 | One-cycle strobe: the verdict is valid |

## Verification
A byte counter that is off by one moves the payload window, the checksum field and the status byte all at once. This shows up at the very next `done` as a spurious bit 1 or bit 2 in `err_vec`, or as `done` arriving one byte early or late. A corrupted CRC register stays hidden until the end of the frame, and then it only appears as bit 1. For that reason the bench checks frames against a known checksum value and against a checksum with a single bit flipped. Counting through idle `rx_valid` cycles, or accepting bytes after the frame has ended, both show up as a `done` in the wrong cycle. The bench compares every cycle, so the error is seen within one clock of the event.

// File: rtl/rsp_chk_pkg.sv
// Package: constants shared by the response integrity checker.
// Assumes nothing beyond the bit positions decoded by software.
package rsp_chk_pkg;
    localparam int ERR_W       = 3;
    localparam int E_REQ_CRC   = 0;   // request CRC flagged by the far end
    localparam int E_RSP_CRC   = 1;   // payload CRC mismatch
    localparam int E_BAD_STAT  = 2;   // status byte not in the expected form
    localparam int ST_REQBAD   = 5;   // status flag bit: request CRC bad
    localparam int ST_TAKEN    = 2;   // status flag bit: work taken
    localparam logic [7:0] ST_IDLE_PAT  = 8'h81;
    localparam logic [7:0] ST_FLAG_MASK = 8'h24;
    localparam int HDR_BYTES   = 4;
    localparam int SUM_BYTES   = 4;
    localparam int TRL_BYTES   = 4;
endpackage

// File: rtl/rsp_chk_seq.sv
// Byte-position tracker. Counts the accepted bytes of one frame and marks
// the payload window, the checksum field, the status byte and the last byte.
// Assumes xfer_len >= 4 and, when chk_len > 0, xfer_len >= chk_len + 12.
module rsp_chk_seq #(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] xfer_len,
    input  logic [LEN_W-1:0] chk_len,
    input  logic             rx_valid,
    output logic             in_pay,
    output logic             in_fld,
    output logic             at_stat,
    output logic             at_last,
    output logic             chk_on
);
    import rsp_chk_pkg::*;
    localparam int XW = LEN_W + 1;

    logic             active;
    logic [LEN_W-1:0] pos, xfer_q, chk_q;
    logic [XW-1:0]    pos_x, pay_end, fld_end;
    logic             take;

    // Decode the current byte position against the latched lengths.
    always_comb begin
        take    = active && rx_valid && !start;
        pos_x   = {1'b0, pos};
        pay_end = {1'b0, chk_q} + XW'(HDR_BYTES);
        fld_end = pay_end + XW'(SUM_BYTES);
        chk_on  = (chk_q != '0);
        in_pay  = take && chk_on && (pos_x >= XW'(HDR_BYTES)) && (pos_x < pay_end);
        in_fld  = take && chk_on && (pos_x >= pay_end) && (pos_x < fld_end);
        at_stat = take && (pos == xfer_q - LEN_W'(TRL_BYTES));
        at_last = take && (pos == xfer_q - LEN_W'(1));
    end

    // Arm on start, advance on each accepted byte, disarm after the last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            pos    <= '0;
            xfer_q <= '0;
            chk_q  <= '0;
        end else if (start) begin
            active <= 1'b1;
            pos    <= '0;
            xfer_q <= xfer_len;
            chk_q  <= chk_len;
        end else if (take) begin
            pos <= pos + LEN_W'(1);
            if (at_last) active <= 1'b0;
        end
    end
endmodule

// File: rtl/rsp_chk_crc32.sv
// Byte-serial CRC-32 engine, reflected form, one byte per enabled cycle.
// Assumes clr and en are never needed in the same cycle (clr wins).
module rsp_chk_crc32 #(
    parameter logic [31:0] POLY = 32'hEDB88320,
    parameter logic [31:0] INIT = 32'hFFFFFFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [31:0] sum
);
    logic [31:0] state, nxt;

    // Fold one byte into the running remainder, least significant bit first.
    always_comb begin
        nxt = state ^ {24'd0, din};
        for (int b = 0; b < 8; b++) begin
            nxt = nxt[0] ? ((nxt >> 1) ^ POLY) : (nxt >> 1);
        end
        sum = ~state;
    end

    // Hold the remainder between bytes; reload on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) state <= INIT;
        else if (en)       state <= nxt;
    end
endmodule

// File: rtl/rsp_chk_verdict.sv
// Collects the sent checksum and the status byte, then forms the error
// vector and the work-accepted flag on the last byte of the frame.
// Assumes the status byte always precedes the last byte.
module rsp_chk_verdict (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic                          in_fld,
    input  logic                          at_stat,
    input  logic                          at_last,
    input  logic                          chk_on,
    input  logic [7:0]                    rx_byte,
    input  logic [31:0]                   crc_calc,
    output logic                          done,
    output logic [rsp_chk_pkg::ERR_W-1:0] err_vec,
    output logic                          work_ok
);
    import rsp_chk_pkg::*;

    logic [31:0]      sent_sum;
    logic [7:0]       stat_q;
    logic [ERR_W-1:0] err_nxt;

    // Judge the captured status and checksum.
    always_comb begin
        err_nxt             = '0;
        err_nxt[E_REQ_CRC]  = stat_q[ST_REQBAD];
        err_nxt[E_RSP_CRC]  = chk_on && (crc_calc != sent_sum);
        err_nxt[E_BAD_STAT] = ((stat_q & ~ST_FLAG_MASK) != ST_IDLE_PAT);
    end

    // Shift in the sent checksum MSB first and capture the status byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sent_sum <= '0;
            stat_q   <= '0;
        end else begin
            if (in_fld)  sent_sum <= {sent_sum[23:0], rx_byte};
            if (at_stat) stat_q   <= rx_byte;
        end
    end

    // Publish the verdict on the last byte; clear it on start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done    <= 1'b0;
            err_vec <= '0;
            work_ok <= 1'b0;
        end else begin
            done <= at_last;
            if (start) begin
                err_vec <= '0;
                work_ok <= 1'b0;
            end else if (at_last) begin
                err_vec <= err_nxt;
                work_ok <= (err_nxt == '0) && stat_q[ST_TAKEN];
            end
        end
    end
endmodule

// File: rtl/rsp_integrity_chk.sv
// Top: response frame integrity checker. Wires the position tracker,
// CRC engine and verdict stage. Assumes lengths as documented in rsp_chk_seq.
module rsp_integrity_chk #(
    parameter int LEN_W = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [LEN_W-1:0]              xfer_len,
    input  logic [LEN_W-1:0]              chk_len,
    input  logic                          rx_valid,
    input  logic [7:0]                    rx_byte,
    output logic [rsp_chk_pkg::ERR_W-1:0] err_vec,
    output logic                          work_ok,
    output logic                          done
);
    logic        in_pay, in_fld, at_stat, at_last, chk_on;
    logic [31:0] crc_calc;

    rsp_chk_seq #(.LEN_W(LEN_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .xfer_len(xfer_len), .chk_len(chk_len), .rx_valid(rx_valid),
        .in_pay(in_pay), .in_fld(in_fld), .at_stat(at_stat),
        .at_last(at_last), .chk_on(chk_on)
    );

    rsp_chk_crc32 u_crc (
        .clk(clk), .rst_n(rst_n), .clr(start), .en(in_pay),
        .din(rx_byte), .sum(crc_calc)
    );

    rsp_chk_verdict u_verdict (
        .clk(clk), .rst_n(rst_n), .start(start), .in_fld(in_fld),
        .at_stat(at_stat), .at_last(at_last), .chk_on(chk_on),
        .rx_byte(rx_byte), .crc_calc(crc_calc),
        .done(done), .err_vec(err_vec), .work_ok(work_ok)
    );
endmodule

// File: rtl/rsp_integrity_chk_sva.sv
// Checker for rsp_integrity_chk: timing of done and the output contract.
module rsp_integrity_chk_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       rx_valid,
    input logic       chk_on,
    input logic [2:0] err_vec,
    input logic       work_ok,
    input logic       done
);
    // R1: outputs cleared right after start
    assert_start_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (err_vec == 3'd0) && !work_ok && !done);
    // R2: done is a single-cycle strobe
    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9: done only follows an accepted byte
    assert_done_after_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(rx_valid));
    // R6: no checksum error when the check is off
    assert_no_crc_err_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !chk_on) |-> !err_vec[1]);
    // R7: acceptance implies a clean vector
    assert_accept_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        work_ok |-> (err_vec == 3'd0));
    // R8: verdict holds outside done and start
    assert_verdict_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !$past(start)) |-> ($stable(err_vec) && $stable(work_ok)));
endmodule

bind rsp_integrity_chk rsp_integrity_chk_sva u_sva (
    .clk(clk), .rst_n(rst_n), .start(start), .rx_valid(rx_valid),
    .chk_on(chk_on), .err_vec(err_vec), .work_ok(work_ok), .done(done)
);

// File: tb/rsp_integrity_chk_bench.sv
// Bench: behavioural frame model compared with the design on every clock.
module rsp_integrity_chk_bench;
    localparam int LEN_W = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [LEN_W-1:0] xfer_len = '0;
    logic [LEN_W-1:0] chk_len = '0;
    logic             rx_valid = 1'b0;
    logic [7:0]       rx_byte = '0;
    logic [2:0]       err_vec;
    logic             work_ok;
    logic             done;

    rsp_integrity_chk #(.LEN_W(LEN_W)) u_rsp_integrity_chk (
        .clk(clk), .rst_n(rst_n), .start(start), .xfer_len(xfer_len),
        .chk_len(chk_len), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .err_vec(err_vec), .work_ok(work_ok), .done(done)
    );

    always #4 clk = ~clk;

    int    n_cmp = 0;
    int    n_bad = 0;
    string tag = "R1";
    bit    finished = 1'b0;

    // Reference CRC-32, reflected, over n bytes of q starting at from.
    function automatic logic [31:0] ref_crc(input logic [7:0] q[$], input int from, input int n);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int i = from; i < from + n; i++) begin
            c = c ^ {24'd0, q[i]};
            for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        return ~c;
    endfunction

    // Reference model state.
    logic [7:0] mq[$];
    bit         m_arm = 0;
    int         m_x = 0, m_c = 0;
    logic       m_done = 0, m_ok = 0;
    logic [2:0] m_err = 0;

    always @(posedge clk) begin
        logic [7:0]  st;
        logic [31:0] sent;
        logic [2:0]  e;
        if (!rst_n) begin
            m_arm = 0; m_done <= 0; m_err <= 0; m_ok <= 0;
        end else begin
            m_done <= 0;
            if (start) begin
                m_arm = 1; mq.delete(); m_x = int'(xfer_len); m_c = int'(chk_len);
                m_err <= 0; m_ok <= 0;
            end else if (m_arm && rx_valid) begin
                mq.push_back(rx_byte);
                if (mq.size() == m_x) begin
                    m_arm = 0;
                    st = mq[m_x-4];
                    e = 3'd0;
                    e[0] = st[5];
                    e[2] = ((st & 8'hDB) != 8'h81);
                    if (m_c != 0) begin
                        sent = {mq[4+m_c], mq[5+m_c], mq[6+m_c], mq[7+m_c]};
                        e[1] = (ref_crc(mq, 4, m_c) != sent);
                    end
                    m_done <= 1; m_err <= e; m_ok <= (e == 3'd0) && st[2];
                end
            end
        end
    end

    // Compare model and design every cycle, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            n_cmp++;
            if (done !== m_done || err_vec !== m_err || work_ok !== m_ok) begin
                n_bad++;
                $display("FAIL %s cycle: act done=%b err=%b ok=%b exp done=%b err=%b ok=%b",
                         tag, done, err_vec, work_ok, m_done, m_err, m_ok);
            end
        end
    end

    task automatic check_final(input string t, input logic [2:0] e, input logic ok);
        n_cmp++;
        if (done !== 1'b1 || err_vec !== e || work_ok !== ok) begin
            n_bad++;
            $display("FAIL %s final: act done=%b err=%b ok=%b exp done=1 err=%b ok=%b",
                     t, done, err_vec, work_ok, e, ok);
        end
    endtask

    logic [7:0] fr[$];

    // Build header, payload, checksum (optionally damaged), padding, trailer.
    task automatic build(input logic [7:0] pay[$], input int pad, input logic [7:0] st,
                         input logic [31:0] damage);
        logic [31:0] c;
        fr.delete();
        for (int i = 0; i < 4; i++) fr.push_back(8'h10 + 8'(i));
        foreach (pay[i]) fr.push_back(pay[i]);
        if (pay.size() != 0) begin
            c = ref_crc(pay, 0, pay.size()) ^ damage;
            fr.push_back(c[31:24]); fr.push_back(c[23:16]);
            fr.push_back(c[15:8]);  fr.push_back(c[7:0]);
        end
        for (int i = 0; i < pad; i++) fr.push_back(8'hA0 ^ 8'(i));
        fr.push_back(st);
        fr.push_back(8'h12); fr.push_back(8'h34); fr.push_back(8'h56);
    endtask

    // Send fr with start; gap inserts idle cycles; sv drives a byte alongside start.
    task automatic send(input int chk, input int gap, input bit sv);
        @(negedge clk);
        start = 1; xfer_len = LEN_W'(fr.size()); chk_len = LEN_W'(chk);
        rx_valid = sv; rx_byte = 8'hFF;
        foreach (fr[i]) begin
            @(negedge clk);
            start = 0; rx_valid = 1; rx_byte = fr[i];
            if (gap != 0 && (i % 3) == 1) begin
                @(negedge clk); rx_valid = 0;
                repeat (gap - 1) @(negedge clk);
            end
        end
        @(negedge clk);
        rx_valid = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: act timeout exp completion");
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] p[$];
        logic [7:0] digits[$];
        int seed;
        repeat (3) @(negedge clk);
        // R1: reset state
        n_cmp++;
        if (done !== 0 || err_vec !== 0 || work_ok !== 0) begin
            n_bad++;
            $display("FAIL R1 reset: act done=%b err=%b ok=%b exp 0 0 0", done, err_vec, work_ok);
        end
        rst_n = 1;
        for (int i = 0; i < 9; i++) digits.push_back(8'h31 + 8'(i));

        tag = "R5"; build(digits, 0, 8'h85, 0);           // known CRC 32'hCBF43926
        n_cmp++;
        if ({fr[13], fr[14], fr[15], fr[16]} !== 32'hCBF43926) begin
            n_bad++; $display("FAIL R5 ref: act %h exp cbf43926", {fr[13], fr[14], fr[15], fr[16]});
        end
        send(9, 0, 0); check_final("R7 accept", 3'b000, 1);

        tag = "R5"; build(digits, 0, 8'h85, 32'h0000_0100);
        send(9, 0, 0); check_final("R5 mismatch", 3'b010, 0);

        tag = "R4"; build(digits, 0, 8'hA1, 0);
        send(9, 0, 0); check_final("R4 reqcrc", 3'b001, 0);

        tag = "R7"; build(digits, 0, 8'hA5, 0);
        send(9, 0, 0); check_final("R7 taken+err", 3'b001, 0);

        tag = "R3"; build(digits, 0, 8'h80, 0);
        send(9, 0, 0); check_final("R3 badstat", 3'b100, 0);

        tag = "R3"; build(digits, 2, 8'hC5, 0);
        send(9, 0, 0); check_final("R3 badstat+pad", 3'b100, 0);

        tag = "R6"; p.delete(); build(p, 6, 8'h85, 0);
        send(0, 0, 0); check_final("R6 nocheck", 3'b000, 1);

        tag = "R9"; build(digits, 1, 8'h81, 0);
        send(9, 2, 0); check_final("R9 gaps", 3'b000, 0);

        tag = "R1"; build(digits, 0, 8'h85, 0);
        send(9, 0, 1); check_final("R1 byte with start", 3'b000, 1);

        // R2/R8: trailing bytes after the frame must change nothing
        tag = "R8";
        repeat (5) begin
            @(negedge clk); rx_valid = 1; rx_byte = 8'h00;
        end
        @(negedge clk); rx_valid = 0;
        n_cmp++;
        if (done !== 0 || err_vec !== 3'b000 || work_ok !== 1) begin
            n_bad++;
            $display("FAIL R2 trailing: act done=%b err=%b ok=%b exp 0 000 1", done, err_vec, work_ok);
        end

        // Longer pseudo-random frames.
        tag = "R5"; seed = 7;
        for (int f = 0; f < 6; f++) begin
            p.delete();
            for (int i = 0; i < 20 + f * 7; i++) begin
                seed = seed * 1103515245 + 12345;
                p.push_back(seed[23:16]);
            end
            build(p, f, (f % 2) ? 8'h85 : 8'h81, (f == 3) ? 32'h8000_0000 : 0);
            send(p.size(), f % 3, 0);
            check_final("R5 random", (f == 3) ? 3'b010 : 3'b000, (f % 2) && f != 3);
        end

        repeat (3) @(negedge clk);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule